// File: doc/BRIEF.md
# Scanline Display Timing Generator

This block paces a raster display by counting clock cycles. Every line is split into a drawing phase and a horizontal-blank phase. A set number of visible lines is followed by a set number of vertical-blank lines, and then the line counter wraps to zero. A four-state machine follows the phase of the line and whether the line is visible or in vertical blank. A down-counter measures the length of each phase.

Software sees one 16-bit control/status word. It holds the two blanking flags, a line-match flag, three interrupt enables and an 8-bit compare line. The block drives three single-cycle interrupt pulses: vertical-blank entry, horizontal-blank entry and line match. It also drives a single-cycle frame-done strobe when the visible region ends. The default parameters give 1232-cycle lines (960 draw and 272 blank) and 160 visible plus 68 blank lines, which makes 280896 cycles per frame.

Top module: `scanline_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, the status word reads 0, `line` reads 0, the timer is in the visible drawing phase, and all four pulse outputs are low.
- R2: Each line spends DRAW_CYC cycles in its drawing phase and then HBL_CYC cycles in horizontal blank. Status bit 1 (hblank flag) is 1 exactly during the blank phase, on visible and vertical-blank lines alike.
- R3: `line` advances by one at the end of each horizontal-blank phase. It counts from 0 up to VIS_LINES+VBL_LINES-1 and then returns to 0.
- R4: Status bit 0 (vblank flag) is 1 on lines VIS_LINES and above and 0 on visible lines. At the wrap to line 0 both blanking flags read 0.
- R5: `frame_done` is high for exactly one cycle per frame: the first cycle of line VIS_LINES.
- R6: When status bit 3 is 1, `vblank_irq` is high for one cycle, in the first cycle of line VIS_LINES. When bit 3 is 0 it stays low.
- R7: When status bit 4 is 1, `hblank_irq` is high for one cycle in the first cycle of every horizontal-blank phase. When bit 4 is 0 it stays low.
- R8: Every time `line` changes, status bit 2 (line-match flag) is loaded with (new line == status bits 15:8) and keeps that value until the next line change. When the loaded value is 1 and status bit 5 is 1, `match_irq` is high for that one cycle. With a compare value of 0, the flag sets at the wrap to line 0.
- R9: A write (`wr_en` high for one cycle) takes the enables from `wr_data` bits 3, 4 and 5 and the compare line from bits 15:8. Writes to bits 2:0 and 7:6 are ignored, bits 7:6 always read 0, and the new values are visible in the cycle after the write.
- R10: One full frame takes (VIS_LINES+VBL_LINES)×(DRAW_CYC+HBL_CYC) cycles, so consecutive `frame_done` pulses are exactly that far apart (280896 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 16 | Control write value |
| status | output | 16 | Control/status word |
| line | output | 8 | Current line number |
| frame_done | output | 1 | End-of-visible-region strobe |
| vblank_irq | output | 1 | Vertical-blank entry pulse |
| hblank_irq | output | 1 | Horizontal-blank entry pulse |
| match_irq | output | 1 | Line-match pulse |

## Verification
Every result is registered at the clock edge that ends a phase, so a flag, the line number or a pulse shows its new value in the cycle directly after that edge. A write shows in `status` one cycle after the edge that samples it. The bench keeps its own frame position by counting edges since reset release. It updates its expected pulses and match flag from that count at each rising edge, and it compares every output at the falling edge that follows, so each check reads the cycle in which the result is due. Shadow copies of the enables and the compare line change only after the write edge, which mirrors the one-cycle write latency.

// File: rtl/scan_timing_pkg.sv
`timescale 1ns/1ps
package scan_timing_pkg;

    localparam int LINE_W = 8;

    // bit 0 = blank part of the line, bit 1 = vertical-blank region
    typedef enum logic [1:0] {
        PH_VIS_DRAW = 2'b00,
        PH_VIS_HBL  = 2'b01,
        PH_VBL_DRAW = 2'b10,
        PH_VBL_HBL  = 2'b11
    } phase_e;

    localparam int ST_VBL_FLAG  = 0;
    localparam int ST_HBL_FLAG  = 1;
    localparam int ST_MATCH     = 2;
    localparam int ST_VBL_EN    = 3;
    localparam int ST_HBL_EN    = 4;
    localparam int ST_MATCH_EN  = 5;
    localparam int ST_CMP_LSB   = 8;

endpackage

// File: rtl/scan_phase_ctr.sv
`timescale 1ns/1ps
module scan_phase_ctr #(
    parameter int DRAW_CYC = 960,
    parameter int HBL_CYC  = 272
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_hblank,
    output logic expire
);
    localparam int MAXC = (DRAW_CYC > HBL_CYC) ? DRAW_CYC : HBL_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = (cnt_q == '0);
        if (expire)
            cnt_d = in_hblank ? CW'(DRAW_CYC - 1) : CW'(HBL_CYC - 1);
        else
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(DRAW_CYC - 1);
        else        cnt_q <= cnt_d;
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> cnt_q == $past(cnt_q) - CW'(1));

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAXC - 1));

endmodule

// File: rtl/scan_line_fsm.sv
`timescale 1ns/1ps
module scan_line_fsm
    import scan_timing_pkg::*;
#(
    parameter int VIS_LINES = 160,
    parameter int VBL_LINES = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    output phase_e            phase,
    output logic [LINE_W-1:0] line_o,
    output logic [LINE_W-1:0] next_line,
    output logic              ev_hbl_enter,
    output logic              ev_line_step,
    output logic              ev_vbl_enter
);
    localparam int TOTAL = VIS_LINES + VBL_LINES;

    typedef struct packed {
        phase_e              ph;
        logic [LINE_W-1:0]   ln;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d        = fsm_q;
        ev_hbl_enter = 1'b0;
        ev_line_step = 1'b0;
        ev_vbl_enter = 1'b0;
        if (expire) begin
            unique case (fsm_q.ph)
                PH_VIS_DRAW: begin
                    fsm_d.ph     = PH_VIS_HBL;
                    ev_hbl_enter = 1'b1;
                end
                PH_VBL_DRAW: begin
                    fsm_d.ph     = PH_VBL_HBL;
                    ev_hbl_enter = 1'b1;
                end
                PH_VIS_HBL: begin
                    ev_line_step = 1'b1;
                    fsm_d.ln     = fsm_q.ln + LINE_W'(1);
                    if (fsm_q.ln == LINE_W'(VIS_LINES - 1)) begin
                        fsm_d.ph     = PH_VBL_DRAW;
                        ev_vbl_enter = 1'b1;
                    end else begin
                        fsm_d.ph = PH_VIS_DRAW;
                    end
                end
                PH_VBL_HBL: begin
                    ev_line_step = 1'b1;
                    if (fsm_q.ln == LINE_W'(TOTAL - 1)) begin
                        fsm_d.ln = '0;
                        fsm_d.ph = PH_VIS_DRAW;
                    end else begin
                        fsm_d.ln = fsm_q.ln + LINE_W'(1);
                        fsm_d.ph = PH_VBL_DRAW;
                    end
                end
                default: fsm_d = fsm_q;
            endcase
        end
        next_line = fsm_d.ln;
        phase     = fsm_q.ph;
        line_o    = fsm_q.ln;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.ph <= PH_VIS_DRAW;
            fsm_q.ln <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_o < LINE_W'(TOTAL));

    // R4
    region_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase[1] == (line_o >= LINE_W'(VIS_LINES)));

    // R3
    line_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> $past(phase[0]));

endmodule

// File: rtl/scan_status.sv
`timescale 1ns/1ps
module scan_status
    import scan_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    input  phase_e            phase,
    input  logic [LINE_W-1:0] next_line,
    input  logic              ev_hbl_enter,
    input  logic              ev_line_step,
    input  logic              ev_vbl_enter,
    output logic [15:0]       status,
    output logic              vblank_irq,
    output logic              hblank_irq,
    output logic              match_irq,
    output logic              frame_done
);
    typedef struct packed {
        logic              vbl_en;
        logic              hbl_en;
        logic              match_en;
        logic [LINE_W-1:0] cmp;
        logic              match;
        logic              virq;
        logic              hirq;
        logic              mirq;
        logic              fdone;
    } st_t;

    st_t st_d, st_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[7:6], wr_data[2:0]};

    always_comb begin
        st_d       = st_q;
        st_d.virq  = ev_vbl_enter & st_q.vbl_en;
        st_d.hirq  = ev_hbl_enter & st_q.hbl_en;
        st_d.fdone = ev_vbl_enter;
        st_d.mirq  = 1'b0;
        if (ev_line_step) begin
            st_d.match = (next_line == st_q.cmp);
            st_d.mirq  = (next_line == st_q.cmp) & st_q.match_en;
        end
        if (wr_en) begin
            st_d.vbl_en   = wr_data[ST_VBL_EN];
            st_d.hbl_en   = wr_data[ST_HBL_EN];
            st_d.match_en = wr_data[ST_MATCH_EN];
            st_d.cmp      = wr_data[ST_CMP_LSB +: LINE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status                          = '0;
        status[ST_VBL_FLAG]             = phase[1];
        status[ST_HBL_FLAG]             = phase[0];
        status[ST_MATCH]                = st_q.match;
        status[ST_VBL_EN]               = st_q.vbl_en;
        status[ST_HBL_EN]               = st_q.hbl_en;
        status[ST_MATCH_EN]             = st_q.match_en;
        status[ST_CMP_LSB +: LINE_W]    = st_q.cmp;
        vblank_irq                      = st_q.virq;
        hblank_irq                      = st_q.hirq;
        match_irq                       = st_q.mirq;
        frame_done                      = st_q.fdone;
    end

    // R7
    hirq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_irq |-> status[ST_HBL_FLAG]);

    // R6
    virq_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> (status[ST_VBL_FLAG] && frame_done));

    // R8
    mirq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> status[ST_MATCH]);

    // R5
    fdone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9
    cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status[15:8] == $past(wr_data[15:8]));

endmodule

// File: rtl/scanline_timer.sv
`timescale 1ns/1ps
module scanline_timer
    import scan_timing_pkg::*;
#(
    parameter int DRAW_CYC  = 960,
    parameter int HBL_CYC   = 272,
    parameter int VIS_LINES = 160,
    parameter int VBL_LINES = 68
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] status,
    output logic [7:0]  line,
    output logic        frame_done,
    output logic        vblank_irq,
    output logic        hblank_irq,
    output logic        match_irq
);
    phase_e            phase;
    logic              expire;
    logic [LINE_W-1:0] next_line;
    logic              ev_hbl_enter, ev_line_step, ev_vbl_enter;

    scan_phase_ctr #(
        .DRAW_CYC (DRAW_CYC),
        .HBL_CYC  (HBL_CYC)
    ) i_phase_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_hblank (phase[0]),
        .expire    (expire)
    );

    scan_line_fsm #(
        .VIS_LINES (VIS_LINES),
        .VBL_LINES (VBL_LINES)
    ) i_line_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .phase        (phase),
        .line_o       (line),
        .next_line    (next_line),
        .ev_hbl_enter (ev_hbl_enter),
        .ev_line_step (ev_line_step),
        .ev_vbl_enter (ev_vbl_enter)
    );

    scan_status i_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .phase        (phase),
        .next_line    (next_line),
        .ev_hbl_enter (ev_hbl_enter),
        .ev_line_step (ev_line_step),
        .ev_vbl_enter (ev_vbl_enter),
        .status       (status),
        .vblank_irq   (vblank_irq),
        .hblank_irq   (hblank_irq),
        .match_irq    (match_irq),
        .frame_done   (frame_done)
    );

    // R4
    wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line) != 8'd0 && line == 8'd0) |-> (status[1:0] == 2'b00));

endmodule

// File: tb/test_scanline_timer.sv
`timescale 1ns/1ps
module test_scanline_timer;
    localparam int DR  = 6;
    localparam int HB  = 3;
    localparam int NV  = 4;
    localparam int NB  = 3;
    localparam int LN  = DR + HB;
    localparam int FR  = (NV + NB) * LN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] status;
    logic [7:0]  line;
    logic        frame_done, vblank_irq, hblank_irq, match_irq;

    int n_tot = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    int k = 0;
    int mp, mo, ml;
    logic m_match = 0, m_mirq = 0, m_hirq = 0, m_virq = 0, m_fd = 0;
    logic [7:0] sh_cmp = '0;
    logic [2:0] sh_en  = '0;  // {match, hblank, vblank}

    always #2 clk = ~clk;

    scanline_timer #(
        .DRAW_CYC (DR),
        .HBL_CYC  (HB),
        .VIS_LINES(NV),
        .VBL_LINES(NB)
    ) i_scanline_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .line(line), .frame_done(frame_done),
        .vblank_irq(vblank_irq), .hblank_irq(hblank_irq), .match_irq(match_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            k <= 0; m_match <= 0; m_mirq <= 0; m_hirq <= 0; m_virq <= 0; m_fd <= 0;
        end else begin
            mp = (k + 1) % FR;
            mo = mp % LN;
            ml = mp / LN;
            k      <= k + 1;
            m_hirq <= (mo == DR) && sh_en[1];
            m_fd   <= (mp == NV * LN);
            m_virq <= (mp == NV * LN) && sh_en[0];
            if (mo == 0) begin
                m_match <= (ml == int'(sh_cmp));
                m_mirq  <= (ml == int'(sh_cmp)) && sh_en[2];
            end else begin
                m_mirq  <= 1'b0;
            end
        end
    end

    function automatic int e_line();  return (k % FR) / LN;          endfunction
    function automatic int e_hbl();   return ((k % FR) % LN) >= DR;   endfunction
    function automatic int e_vbl();   return e_line() >= NV;          endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tot++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (k=%0d)", req, act, exp, k);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        sh_cmp = v[15:8];
        sh_en  = v[5:3];
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", status, 0);
        chk("R1 line in reset", line, 0);
        chk("R1 pulses in reset", {frame_done, vblank_irq, hblank_irq, match_irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after release", status, 0);
        chk("R1 line after release", line, 0);
    endtask

    task automatic t_line_phase;
        int hcnt = 0;
        for (int c = 0; c < 2 * LN; c++) begin
            @(negedge clk);
            chk("R2 hblank flag", status[1], e_hbl());
            if (status[1]) hcnt++;
        end
        chk("R2 blank cycles over two lines", hcnt, 2 * HB);
    endtask

    task automatic t_frame_walk;
        int first = -1;
        int second = -1;
        int npulse = 0;
        for (int c = 0; c < 2 * FR; c++) begin
            @(negedge clk);
            chk("R3 line", line, e_line());
            chk("R4 vblank flag", status[0], e_vbl());
            chk("R2 hblank flag", status[1], e_hbl());
            chk("R5 frame_done", frame_done, m_fd);
            if (k % FR == 0)
                chk("R4 flags at wrap", status[1:0], 0);
            if (frame_done) begin
                npulse++;
                if (first < 0) first = k; else if (second < 0) second = k;
            end
        end
        chk("R5 pulses in two frames", npulse, 2);
        chk("R10 frame length", second - first, FR);
    endtask

    task automatic t_fields;
        wr(16'hFFFF);
        chk("R9 writable bits after all-ones", status & 16'hFFF8, 16'hFF38);
        chk("R9 read-only bits keep status", status[2:0], {m_match, 1'(e_hbl()), 1'(e_vbl())});
        wr(16'h00C7);
        chk("R9 only ignored bits written", status & 16'hFFF8, 0);
        chk("R9 ignored low bits", status[2:0], {m_match, 1'(e_hbl()), 1'(e_vbl())});
        wr(16'h0000);
    endtask

    task automatic t_blank_irqs;
        int nh = 0;
        int nv = 0;
        wr(16'h0018);
        for (int c = 0; c < FR; c++) begin
            @(negedge clk);
            chk("R7 hblank_irq", hblank_irq, m_hirq);
            chk("R6 vblank_irq", vblank_irq, m_virq);
            if (hblank_irq) nh++;
            if (vblank_irq) nv++;
        end
        chk("R7 hblank pulses per frame", nh, NV + NB);
        chk("R6 vblank pulses per frame", nv, 1);
        wr(16'h0000);
        nh = 0; nv = 0;
        for (int c = 0; c < FR; c++) begin
            @(negedge clk);
            if (hblank_irq) nh++;
            if (vblank_irq) nv++;
        end
        chk("R7 no hblank pulse when disabled", nh, 0);
        chk("R6 no vblank pulse when disabled", nv, 0);
    endtask

    task automatic t_match;
        int nm = 0;
        wr(16'h0220);
        for (int c = 0; c < FR; c++) begin
            @(negedge clk);
            chk("R8 match flag", status[2], m_match);
            chk("R8 match_irq", match_irq, m_mirq);
            if (match_irq) nm++;
        end
        chk("R8 match pulses per frame", nm, 1);
        wr(16'h0020);
        while (k % FR != 0) @(negedge clk);
        chk("R8 flag at wrap with compare 0", status[2], 1);
        chk("R8 irq at wrap with compare 0", match_irq, 1);
        chk("R8 line at wrap", line, 0);
        repeat (LN) @(negedge clk);
        chk("R8 flag clears on next line", status[2], 0);
        wr(16'h0000);
    endtask

    initial begin
        t_reset();
        t_line_phase();
        t_frame_walk();
        t_fields();
        t_blank_irqs();
        t_match();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

endmodule